// File: doc/BRIEF.md
# Infrared Pulse-Width Capture Engine

The engine watches the demodulated output of an infrared receiver, an active-low line where low means light is present, and measures each pulse and each space between edges. The unit of measurement is a programmable sampling tick. Each measured interval is stored as one byte. Bytes strictly alternate, starting with a pulse. They are packed four to a 32-bit word, and software reads them back over a small word-addressed register port.

A space that stays idle for a programmed number of timeout units ends the message. A zero byte is written as the end marker, a status bit is set, and an interrupt can be raised. From then on the line is ignored until software writes the restart bit. A restart empties the capture words and re-arms the engine. The next accepted low level then becomes the first pulse.

The register map is word-addressed, with 6-bit addresses:

- 0: configuration. Bit 0 is run, bit 13 is detect enable, bits 22:16 are the idle limit.
- 1: tick divider, bits 15:0.
- 2: timeout unit length, bits 15:0.
- 3: hold count for the input filter, bits 12:8.
- 4: restart. Writing 1 to bit 0 triggers it; the register reads as 0.
- 5: interrupt enable, bit 0.
- 6: interrupt status, bit 0, write 1 to clear.
- 32 to 48: the 17 capture words.

Top module: `ir_pulse_capture`

## Requirements
- R1: Slot n holds the nth interval after the capture starts. Even slots are pulses and odd slots are spaces. Slot n sits in capture word 32+n/4, at bits 8*(n%4)+7 down to 8*(n%4).
- R2: The tick divider register holds D, and one sampling tick occurs every D+1 clock cycles. A stored width is the interval's length in ticks.
- R3: An interval of 255 ticks or more is stored as 0xFF and never wraps.
- R4: The idle limit is L (config bits 22:16) and the unit length register holds P. If L is nonzero and a space lasts L*(P+1) ticks, the current slot is written as zero, every later slot stays zero, and the interrupt status is set. L = 0 disables the timeout.
- R5: At most 68 intervals are stored, and later ones are discarded. When the buffer fills before the timeout, the last slot keeps its width and is not zero.
- R6: A change of the input level is accepted only after the new level has held for G consecutive ticks, where G is bits 12:8 of register 3; G of 0 and G of 1 both mean one tick. A shorter glitch does not split an interval.
- R7: Ticks, filtering and capture advance only while config bit 0 and bit 13 are both 1. Otherwise the engine's state does not change.
- R8: Writing 1 to bit 0 of register 4 zeroes every capture word and returns the engine to waiting. The first accepted low level after that starts slot 0.
- R9: After completion, input edges change no capture word until the next restart.
- R10: The status bit is set on completion and cleared by writing 1 to bit 0 of register 6. The irq output equals status AND enable (register 5, bit 0).
- R11: After reset, every register and capture word reads as zero and irq is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ir_rx_n | input | 1 | Demodulated receiver line, low = pulse |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 6 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| irq | output | 1 | Completion interrupt |

## Verification
On every cycle, the assertions check several structural properties:

- Ticks are spaced by the divider.
- A filter acceptance only follows a tick.
- The slot index never passes 68.
- Once complete, the engine stores nothing and stays complete until a restart, and a restart returns it to an empty waiting state.
- The status bit rises only after a completion.

Only the directed scenarios can show the stored values themselves: the widths in ticks, saturation, the zero end marker, glitch rejection, the full-buffer case, and the effect of the enable bits. The bench does this by reading the capture words back after shaped input sequences.

// File: rtl/ir_cap_pkg.sv
// Package: shared constants for the pulse-width capture engine.
// Assumes word addressing with a 6-bit address; capture words start at 32.
package ir_cap_pkg;
    localparam int ADDR_W      = 6;
    localparam int LIM_W       = 7;
    localparam int FILT_W      = 5;
    localparam int CFG_RUN_BIT = 0;
    localparam int CFG_DET_BIT = 13;
    localparam int CFG_LIM_LSB = 16;
    localparam int FILT_LSB    = 8;
    localparam int A_CFG       = 0;
    localparam int A_TICK      = 1;
    localparam int A_UNIT      = 2;
    localparam int A_FILT      = 3;
    localparam int A_RESTART   = 4;
    localparam int A_IEN       = 5;
    localparam int A_ISTAT     = 6;
    localparam int A_CAP       = 32;
    localparam logic [7:0] WIDTH_MAX = 8'hFF;

    typedef enum logic [1:0] {
        CS_WAIT = 2'd0,
        CS_CAPT = 2'd1,
        CS_DONE = 2'd2
    } cap_state_t;
endpackage

// File: rtl/ir_cap_tick.sv
// Module: sampling tick generator. Emits a one-cycle strobe every div+1
// clocks while en is high; the counter is held at zero while disabled.
module ir_cap_tick #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    // Divide the clock down to the sampling tick.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            cnt  <= '0;
            tick <= 1'b0;
        end else if (cnt >= div) begin
            cnt  <= '0;
            tick <= 1'b1;
        end else begin
            cnt  <= cnt + 1'b1;
            tick <= 1'b0;
        end
    end
endmodule

// File: rtl/ir_cap_filter.sv
// Module: input synchronizer and de-glitch filter. The line is active low;
// lvl is 1 for a pulse. A new level is taken after it holds for hold_ticks
// sampled ticks (0 or 1 = one tick); acc strobes in the cycle after that tick.
module ir_cap_filter
    import ir_cap_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              rx_n,
    input  logic [FILT_W-1:0] hold_ticks,
    output logic              lvl,
    output logic              acc
);
    logic [1:0]        sync;
    logic [FILT_W-1:0] run;
    logic              raw;

    assign raw = sync[1];

    // Bring the asynchronous line into the clock domain, inverted to active high.
    always_ff @(posedge clk) begin
        if (!rst_n) sync <= 2'b00;
        else        sync <= {sync[0], ~rx_n};
    end

    // Count ticks of disagreement and accept the level once it has held long enough.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl <= 1'b0;
            acc <= 1'b0;
            run <= '0;
        end else begin
            acc <= 1'b0;
            if (tick) begin
                if (raw != lvl) begin
                    if (({1'b0, run} + 1'b1) >= {1'b0, hold_ticks}) begin
                        lvl <= raw;
                        acc <= 1'b1;
                        run <= '0;
                    end else begin
                        run <= run + 1'b1;
                    end
                end else begin
                    run <= '0;
                end
            end
        end
    end
endmodule

// File: rtl/ir_cap_core.sv
// Module: width counter, idle timeout and byte storage. Works on the tick
// delayed by one cycle so it lines up with the filter's acc strobe. Slots are
// flops cleared by restart; slot s is exposed at cap_flat[8s+7:8s].
module ir_cap_core
    import ir_cap_pkg::*;
#(
    parameter int SLOTS = 68,
    parameter int PER_W = 16,
    parameter int IDX_W = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick,
    input  logic               acc,
    input  logic               lvl,
    input  logic               restart,
    input  logic [LIM_W-1:0]   limit,
    input  logic [PER_W-1:0]   unit_per,
    output logic [SLOTS*8-1:0] cap_flat,
    output logic [IDX_W-1:0]   cap_idx,
    output logic               in_done,
    output logic               slot_we,
    output logic               done
);
    cap_state_t       st;
    logic             tick_d;
    logic [7:0]       wcnt;
    logic [PER_W-1:0] sub;
    logic [LIM_W-1:0] units;
    logic [7:0]       slot_q [SLOTS];
    logic [7:0]       slot_val;
    logic             room, unit_end, expire, step;

    assign in_done = (st == CS_DONE);
    assign step    = tick_d && (st == CS_CAPT);

    // Decide whether this cycle writes a width, an end marker, or nothing.
    always_comb begin
        room     = (cap_idx < IDX_W'(SLOTS));
        unit_end = step && !acc && !lvl && (limit != '0) && (sub == unit_per);
        expire   = unit_end && (({1'b0, units} + 1'b1) >= {1'b0, limit});
        slot_we  = 1'b0;
        slot_val = 8'h00;
        if (step && acc && room) begin
            slot_we  = 1'b1;
            slot_val = (wcnt == WIDTH_MAX) ? WIDTH_MAX : wcnt + 8'd1;
        end else if (expire && room) begin
            slot_we  = 1'b1;
            slot_val = 8'h00;
        end
    end

    // Sequence the capture: wait, measure, finish; restart overrides all.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= CS_WAIT;
            tick_d  <= 1'b0;
            done    <= 1'b0;
            cap_idx <= '0;
            wcnt    <= '0;
            sub     <= '0;
            units   <= '0;
        end else begin
            tick_d <= tick;
            done   <= 1'b0;
            if (restart) begin
                st      <= CS_WAIT;
                cap_idx <= '0;
                wcnt    <= '0;
                sub     <= '0;
                units   <= '0;
            end else if (tick_d) begin
                case (st)
                    CS_WAIT: begin
                        if (acc && lvl) begin
                            st    <= CS_CAPT;
                            wcnt  <= '0;
                            sub   <= '0;
                            units <= '0;
                        end
                    end
                    CS_CAPT: begin
                        if (acc) begin
                            if (room) cap_idx <= cap_idx + 1'b1;
                            wcnt  <= '0;
                            sub   <= '0;
                            units <= '0;
                        end else begin
                            if (wcnt != WIDTH_MAX) wcnt <= wcnt + 8'd1;
                            if (expire) begin
                                st   <= CS_DONE;
                                done <= 1'b1;
                            end else if (unit_end) begin
                                sub   <= '0;
                                units <= units + 1'b1;
                            end else if (!lvl && (limit != '0)) begin
                                sub <= sub + 1'b1;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // Hold the captured bytes; restart or reset empties them.
    always_ff @(posedge clk) begin
        for (int s = 0; s < SLOTS; s++) begin
            if (!rst_n || restart)                        slot_q[s] <= 8'h00;
            else if (slot_we && (cap_idx == IDX_W'(s)))   slot_q[s] <= slot_val;
        end
    end

    for (genvar s = 0; s < SLOTS; s++) begin : g_pack
        assign cap_flat[s*8 +: 8] = slot_q[s];
    end
endmodule

// File: rtl/ir_pulse_capture.sv
// Module: top of the capture engine. Holds the software-visible registers,
// the read mux and the interrupt, and connects tick, filter and core.
// Assumes single-cycle register writes and a combinational read path.
module ir_pulse_capture
    import ir_cap_pkg::*;
#(
    parameter int DIV_W     = 16,
    parameter int PER_W     = 16,
    parameter int NUM_WORDS = 17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ir_rx_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq
);
    localparam int SLOTS = NUM_WORDS * 4;
    localparam int IDX_W = $clog2(SLOTS + 1);

    logic              cfg_run, cfg_det, int_en, int_stat;
    logic [LIM_W-1:0]  cfg_lim;
    logic [DIV_W-1:0]  tick_div;
    logic [PER_W-1:0]  unit_per;
    logic [FILT_W-1:0] filt_g;
    logic              tick, acc, lvl, done, restart, in_done, slot_we;
    logic [IDX_W-1:0]  cap_idx;
    logic [SLOTS*8-1:0] cap_flat;

    function automatic logic hit(input logic [ADDR_W-1:0] a, input int r);
        return a == ADDR_W'(r);
    endfunction

    assign restart = bus_wr && hit(bus_addr, A_RESTART) && bus_wdata[0];
    assign irq     = int_stat && int_en;

    // Capture software writes into the configuration registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_run  <= 1'b0;
            cfg_det  <= 1'b0;
            cfg_lim  <= '0;
            tick_div <= '0;
            unit_per <= '0;
            filt_g   <= '0;
            int_en   <= 1'b0;
        end else if (bus_wr) begin
            if (hit(bus_addr, A_CFG)) begin
                cfg_run <= bus_wdata[CFG_RUN_BIT];
                cfg_det <= bus_wdata[CFG_DET_BIT];
                cfg_lim <= bus_wdata[CFG_LIM_LSB +: LIM_W];
            end
            if (hit(bus_addr, A_TICK))  tick_div <= bus_wdata[DIV_W-1:0];
            if (hit(bus_addr, A_UNIT))  unit_per <= bus_wdata[PER_W-1:0];
            if (hit(bus_addr, A_FILT))  filt_g   <= bus_wdata[FILT_LSB +: FILT_W];
            if (hit(bus_addr, A_IEN))   int_en   <= bus_wdata[0];
        end
    end

    // Set status on completion; a write of 1 clears it, completion wins.
    always_ff @(posedge clk) begin
        if (!rst_n)                                         int_stat <= 1'b0;
        else if (done)                                      int_stat <= 1'b1;
        else if (bus_wr && hit(bus_addr, A_ISTAT) && bus_wdata[0]) int_stat <= 1'b0;
    end

    // Select the register or capture word addressed by the bus.
    always_comb begin
        bus_rdata = 32'h0;
        case (bus_addr)
            ADDR_W'(A_CFG): begin
                bus_rdata[CFG_RUN_BIT]             = cfg_run;
                bus_rdata[CFG_DET_BIT]             = cfg_det;
                bus_rdata[CFG_LIM_LSB +: LIM_W]    = cfg_lim;
            end
            ADDR_W'(A_TICK):  bus_rdata[DIV_W-1:0]          = tick_div;
            ADDR_W'(A_UNIT):  bus_rdata[PER_W-1:0]          = unit_per;
            ADDR_W'(A_FILT):  bus_rdata[FILT_LSB +: FILT_W] = filt_g;
            ADDR_W'(A_IEN):   bus_rdata[0]                  = int_en;
            ADDR_W'(A_ISTAT): bus_rdata[0]                  = int_stat;
            default: ;
        endcase
        for (int w = 0; w < NUM_WORDS; w++) begin
            if (bus_addr == ADDR_W'(A_CAP + w)) bus_rdata = cap_flat[w*32 +: 32];
        end
    end

    ir_cap_tick #(.DIV_W(DIV_W)) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (cfg_run && cfg_det),
        .div  (tick_div),
        .tick (tick)
    );

    ir_cap_filter u_filter (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .rx_n      (ir_rx_n),
        .hold_ticks(filt_g),
        .lvl       (lvl),
        .acc       (acc)
    );

    ir_cap_core #(.SLOTS(SLOTS), .PER_W(PER_W), .IDX_W(IDX_W)) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .acc     (acc),
        .lvl     (lvl),
        .restart (restart),
        .limit   (cfg_lim),
        .unit_per(unit_per),
        .cap_flat(cap_flat),
        .cap_idx (cap_idx),
        .in_done (in_done),
        .slot_we (slot_we),
        .done    (done)
    );
endmodule

// File: rtl/ir_pulse_capture_chk.sv
// Module: property checker for the capture engine, bound into the top.
// Assumes the top's internal names tick, acc, done, restart, int_stat,
// cap_idx, in_done, slot_we and tick_div.
module ir_pulse_capture_chk #(
    parameter int SLOTS = 68,
    parameter int IDX_W = 7,
    parameter int DIV_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick,
    input logic             acc,
    input logic             done,
    input logic             restart,
    input logic             int_stat,
    input logic [IDX_W-1:0] cap_idx,
    input logic             in_done,
    input logic             slot_we,
    input logic [DIV_W-1:0] tick_div
);
    a_r2_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && (tick_div != '0)) |=> !tick);

    a_r6_accept_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
        acc |-> $past(tick));

    a_r5_index_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cap_idx <= IDX_W'(SLOTS));

    a_r9_no_store_when_done: assert property (@(posedge clk) disable iff (!rst_n)
        in_done |-> !slot_we);

    a_r9_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (in_done && !restart) |=> in_done);

    a_r8_restart_empties: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> ((cap_idx == '0) && !in_done));

    a_r10_status_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(int_stat) |-> $past(done));
endmodule

bind ir_pulse_capture ir_pulse_capture_chk #(
    .SLOTS(SLOTS),
    .IDX_W(IDX_W),
    .DIV_W(DIV_W)
) i_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .acc     (acc),
    .done    (done),
    .restart (restart),
    .int_stat(int_stat),
    .cap_idx (cap_idx),
    .in_done (in_done),
    .slot_we (slot_we),
    .tick_div(tick_div)
);

// File: tb/test_ir_pulse_capture.sv
// Directed bench: one task per scenario, each checking its own results.
module test_ir_pulse_capture;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ir_rx_n = 1'b1;
    logic        bus_wr = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;
    int          n_tests = 0;
    int          n_fail = 0;

    localparam int CLKS_PER_TICK = 4;   // divider value 3

    always #10 clk = ~clk;              // 50 MHz

    ir_pulse_capture i_ir_pulse_capture (
        .clk      (clk),
        .rst_n    (rst_n),
        .ir_rx_n  (ir_rx_n),
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .irq      (irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 6'(a); bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = 6'(a);
        #1 d = bus_rdata;
    endtask

    task automatic hold(input logic v, input int ticks);
        ir_rx_n = v;
        repeat (ticks * CLKS_PER_TICK) @(negedge clk);
    endtask

    // Program divider 3, timeout unit per+1 ticks, limit lim, filter g; clear status; restart.
    task automatic setup(input int lim, input int per, input int g);
        wr(1, 32'd3);
        wr(2, 32'(per));
        wr(3, 32'(g) << 8);
        wr(0, (32'(lim) << 16) | 32'h2001);
        wr(6, 32'h1);
        wr(4, 32'h1);
    endtask

    task automatic t_reset;
        logic [31:0] d;
        for (int a = 0; a < 7; a++) begin
            rd(a, d); check("R11 reg after reset", d, 32'h0);
        end
        rd(32, d); check("R11 first capture word", d, 32'h0);
        rd(48, d); check("R11 last capture word", d, 32'h0);
        check("R11 irq low", {31'h0, irq}, 32'h0);
    endtask

    task automatic t_basic;
        logic [31:0] d;
        setup(2, 9, 1);
        wr(5, 32'h1);
        hold(1'b1, 5);
        hold(1'b0, 5); hold(1'b1, 7); hold(1'b0, 3); hold(1'b1, 12); hold(1'b0, 9);
        hold(1'b1, 40);
        rd(32, d); check("R1 R2 word0 widths", d, 32'h0C030705);
        rd(33, d); check("R4 word1 last pulse then end marker", d, 32'h00000009);
        rd(34, d); check("R4 later word zero", d, 32'h0);
        rd(6, d);  check("R10 status set on completion", d, 32'h1);
        check("R10 irq high", {31'h0, irq}, 32'h1);
    endtask

    task automatic t_ignore;
        logic [31:0] d;
        wr(6, 32'h1);
        check("R10 irq cleared by write-one", {31'h0, irq}, 32'h0);
        hold(1'b0, 6); hold(1'b1, 6); hold(1'b0, 6); hold(1'b1, 40);
        rd(32, d); check("R9 word0 unchanged after done", d, 32'h0C030705);
        rd(33, d); check("R9 word1 unchanged after done", d, 32'h00000009);
        rd(6, d);  check("R9 no new completion", d, 32'h0);
    endtask

    task automatic t_restart;
        logic [31:0] d;
        wr(4, 32'h1);
        rd(32, d); check("R8 word0 cleared", d, 32'h0);
        rd(33, d); check("R8 word1 cleared", d, 32'h0);
        hold(1'b0, 4); hold(1'b1, 40);
        rd(32, d); check("R8 first pulse in slot 0", d, 32'h00000004);
    endtask

    task automatic t_irq;
        logic [31:0] d;
        wr(6, 32'h1);
        wr(5, 32'h0);
        wr(4, 32'h1);
        hold(1'b0, 3); hold(1'b1, 40);
        rd(6, d); check("R10 status with enable off", d, 32'h1);
        check("R10 irq masked", {31'h0, irq}, 32'h0);
        wr(5, 32'h1);
        check("R10 irq after enable", {31'h0, irq}, 32'h1);
        wr(6, 32'h1);
        check("R10 irq after clear", {31'h0, irq}, 32'h0);
        rd(6, d); check("R10 status after clear", d, 32'h0);
    endtask

    task automatic t_saturate;
        logic [31:0] d;
        setup(40, 9, 1);
        hold(1'b0, 300); hold(1'b1, 260); hold(1'b0, 2); hold(1'b1, 420);
        rd(32, d); check("R3 long pulse and space saturate", d, 32'h0002FFFF);
        rd(6, d);  check("R4 long timeout completes", d, 32'h1);
    endtask

    task automatic t_glitch;
        logic [31:0] d;
        setup(2, 9, 3);
        hold(1'b0, 4); hold(1'b1, 2); hold(1'b0, 4);
        hold(1'b1, 6); hold(1'b0, 5); hold(1'b1, 40);
        rd(32, d); check("R6 short glitch rejected", d, 32'h0005060A);
    endtask

    task automatic t_full;
        logic [31:0] d;
        setup(2, 9, 1);
        for (int i = 0; i < 35; i++) begin
            hold(1'b0, 2);
            if (i < 34) hold(1'b1, 2);
        end
        hold(1'b1, 40);
        for (int w = 0; w < 17; w++) begin
            rd(32 + w, d); check("R5 full buffer word", d, 32'h02020202);
        end
        rd(6, d); check("R5 completion after full buffer", d, 32'h1);
    endtask

    task automatic t_enable;
        logic [31:0] d;
        setup(2, 9, 1);
        wr(0, (32'd2 << 16) | 32'h1);
        hold(1'b0, 5); hold(1'b1, 5); hold(1'b0, 5); hold(1'b1, 40);
        rd(32, d); check("R7 nothing stored while detect off", d, 32'h0);
        rd(6, d);  check("R7 no completion while detect off", d, 32'h0);
        wr(0, (32'd2 << 16) | 32'h2001);
        hold(1'b0, 4); hold(1'b1, 40);
        rd(32, d); check("R7 capture after re-enable", d, 32'h00000004);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_basic();
        t_ignore();
        t_restart();
        t_irq();
        t_saturate();
        t_glitch();
        t_full();
        t_enable();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule